// File: doc/BRIEF.md
# DMA Job Register File with Descriptor Chaining

This block is a slave register file on a pipelined bus. It holds the parameters of one DMA job and hands them to two transfer engines, one for each direction. Software writes the carrier address, the 64-bit host address, the byte count, a 64-bit pointer to the next descriptor and an attribute word. A write with the go bit set then launches the job, and the same write latches a 2-bit byte-swap mode. The block sends one start strobe to the engine chosen by the direction attribute. When the engine reports completion or failure, the block raises an interrupt. Software reads the status and then clears the interrupt with an explicit write.

When a segment finishes and its attribute word has the chain bit set, the block does not interrupt. It pulses a fetch request and waits for the seven descriptor words to arrive on a valid-qualified input. The words come in this order: carrier address, host low, host high, count, next low, next high, attributes. The block loads them into the job registers and restarts the engine that the new attribute word selects. The chain ends at the first descriptor whose chain bit is clear, or at the first error. A small lane-swap path applies the latched swap mode to a data word.

Top module: `dma_job_regs`

## Requirements
- R1: Every bus request (cyc and stb high) is acknowledged in the next cycle, and stall stays low. Word offsets are: control 0x00, status 0x04, interrupt clear 0x08, host low 0x0C, host high 0x10, count 0x14, next low 0x18, next high 0x1C, attributes 0x20, carrier address 0x24. A read returns the register at its offset, with the ack.
- R2: A write to 0x00 with bit 0 set, while the status is not busy, sets status busy (2). In the following cycle it gives a one-cycle start strobe: on the host-to-carrier strobe if attribute bit 0 is 1, otherwise on the carrier-to-host strobe. The direction output equals attribute bit 0.
- R3: Bits 3:2 of the starting write are latched as the swap mode and held until the next accepted start. On the swap path, mode 0 passes the word unchanged, mode 1 reverses all four bytes, mode 2 exchanges the 16-bit halves, and mode 3 swaps the bytes inside each half.
- R4: When a segment completes with attribute bit 1 clear, the status becomes done (1) and the interrupt rises.
- R5: When a segment completes with attribute bit 1 set, the block gives a one-cycle fetch strobe and keeps status busy without an interrupt. It then loads seven valid descriptor words in the order carrier, host low, host high, count, next low, next high, attributes. After the seventh word it strobes the engine selected by the new attribute bit 0.
- R6: An error input while a segment runs or a descriptor is being fetched ends the chain, sets status error (3) and raises the interrupt.
- R7: A write to 0x00 with bit 1 set while busy ends the job, sets status abort (4) and gives a one-cycle abort strobe, without an interrupt.
- R8: A write to 0x08 with bit 0 set clears the interrupt.
- R9: While the status is busy, writes to the job registers and further start writes are ignored.
- R10: After reset the status is idle (0), the interrupt and all strobes are low, and the job registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cyc_i | input | 1 | Bus cycle |
| stb_i | input | 1 | Bus strobe |
| we_i | input | 1 | Bus write enable |
| adr_i | input | ADDR_W | Byte address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data |
| ack_o | output | 1 | Acknowledge |
| stall_o | output | 1 | Stall, always low |
| carrier_addr_o | output | 32 | Carrier address of the job |
| host_lo_o | output | 32 | Host address low word |
| host_hi_o | output | 32 | Host address high word |
| byte_count_o | output | 32 | Byte count |
| next_lo_o | output | 32 | Next descriptor pointer low |
| next_hi_o | output | 32 | Next descriptor pointer high |
| direction_o | output | 1 | 1 = host to carrier |
| swap_mode_o | output | 2 | Latched byte-swap mode |
| start_h2c_o | output | 1 | Start strobe, host-to-carrier engine |
| start_c2h_o | output | 1 | Start strobe, carrier-to-host engine |
| abort_o | output | 1 | Abort strobe to both engines |
| fetch_next_o | output | 1 | Request for the next descriptor |
| desc_valid_i | input | 1 | Descriptor word valid |
| desc_word_i | input | 32 | Descriptor word |
| seg_done_i | input | 1 | Segment completed |
| seg_error_i | input | 1 | Segment failed |
| swap_din_i | input | 32 | Word into the lane-swap path |
| swap_dout_o | output | 32 | Word after the swap |
| irq_o | output | 1 | Interrupt |

## Verification
A sequencer stuck in the wrong state shows up within one cycle of the next completion or error input. It appears as a missing or misdirected start strobe, a fetch strobe where an interrupt was due, or a status readback that disagrees with the job's history. A descriptor word counter that is off by one puts the chained job's fields in the wrong registers, and the restart then picks the wrong engine. Readback right after the seventh word exposes this. A swap mode latched at the wrong time changes the swap output in the cycle after the offending control write.

// File: rtl/dma_job_pkg.sv
package dma_job_pkg;
   localparam int WORD_W     = 32;
   localparam int DESC_WORDS = 7;

   typedef enum logic [2:0] {
      JS_IDLE  = 3'd0,
      JS_DONE  = 3'd1,
      JS_BUSY  = 3'd2,
      JS_ERROR = 3'd3,
      JS_ABORT = 3'd4
   } job_status_e;

   // word indices (byte offset / 4)
   localparam int RI_CTRL = 0;
   localparam int RI_STAT = 1;
   localparam int RI_ICLR = 2;
   localparam int RI_HLO  = 3;
   localparam int RI_HHI  = 4;
   localparam int RI_CNT  = 5;
   localparam int RI_NLO  = 6;
   localparam int RI_NHI  = 7;
   localparam int RI_ATTR = 8;
   localparam int RI_CARR = 9;
endpackage

// File: rtl/dma_lane_swap.sv
module dma_lane_swap #(
   parameter int W = 32
) (
   input  logic [1:0]   mode_i,
   input  logic [W-1:0] din_i,
   output logic [W-1:0] dout_o
);
   localparam int NB = W / 8;
   localparam int NH = W / 16;

   if (W % 16 != 0) begin : g_bad_width
      $error("dma_lane_swap: W must be a multiple of 16");
   end

   logic [W-1:0] rev_bytes, rev_halves, in_half;

   for (genvar b = 0; b < NB; b++) begin : g_byte
      assign rev_bytes[8*b +: 8] = din_i[8*(NB-1-b) +: 8];
   end

   for (genvar h = 0; h < NH; h++) begin : g_half
      assign rev_halves[16*h +: 16] = din_i[16*(NH-1-h) +: 16];
      assign in_half[16*h +: 16]    = {din_i[16*h +: 8], din_i[16*h+8 +: 8]};
   end

   always_comb begin
      unique case (mode_i)
         2'd0:    dout_o = din_i;
         2'd1:    dout_o = rev_bytes;
         2'd2:    dout_o = rev_halves;
         default: dout_o = in_half;
      endcase
   end
endmodule

// File: rtl/dma_job_seq.sv
module dma_job_seq
   import dma_job_pkg::*;
#(
   parameter int NWORDS = DESC_WORDS,
   localparam int IW    = $clog2(NWORDS)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          go_i,
   input  logic          halt_i,
   input  logic          irq_clr_i,
   input  logic          seg_done_i,
   input  logic          seg_error_i,
   input  logic          desc_valid_i,
   input  logic          chain_i,
   input  logic          dir_i,
   input  logic          desc_dir_i,
   output job_status_e   status_o,
   output logic          busy_o,
   output logic          fetch_o,
   output logic [IW-1:0] word_idx_o,
   output logic          irq_o,
   output logic          start_h2c_o,
   output logic          start_c2h_o,
   output logic          abort_o,
   output logic          fetch_next_o
);
   if (NWORDS < 2) begin : g_bad_words
      $error("dma_job_seq: NWORDS must be at least 2");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FETCH} seq_e;
   seq_e state;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state        <= S_IDLE;
         status_o     <= JS_IDLE;
         word_idx_o   <= '0;
         irq_o        <= 1'b0;
         start_h2c_o  <= 1'b0;
         start_c2h_o  <= 1'b0;
         abort_o      <= 1'b0;
         fetch_next_o <= 1'b0;
      end else begin
         start_h2c_o  <= 1'b0;
         start_c2h_o  <= 1'b0;
         abort_o      <= 1'b0;
         fetch_next_o <= 1'b0;
         if (irq_clr_i) irq_o <= 1'b0;
         unique case (state)
            S_IDLE: if (go_i) begin
               state       <= S_RUN;
               status_o    <= JS_BUSY;
               start_h2c_o <= dir_i;
               start_c2h_o <= !dir_i;
            end
            default: begin
               if (halt_i) begin
                  state    <= S_IDLE;
                  status_o <= JS_ABORT;
                  abort_o  <= 1'b1;
               end else if (seg_error_i) begin
                  state    <= S_IDLE;
                  status_o <= JS_ERROR;
                  irq_o    <= 1'b1;
               end else if (state == S_RUN) begin
                  if (seg_done_i) begin
                     if (chain_i) begin
                        state        <= S_FETCH;
                        word_idx_o   <= '0;
                        fetch_next_o <= 1'b1;
                     end else begin
                        state    <= S_IDLE;
                        status_o <= JS_DONE;
                        irq_o    <= 1'b1;
                     end
                  end
               end else if (desc_valid_i) begin
                  if (word_idx_o == IW'(NWORDS-1)) begin
                     state       <= S_RUN;
                     start_h2c_o <= desc_dir_i;
                     start_c2h_o <= !desc_dir_i;
                  end else begin
                     word_idx_o <= word_idx_o + 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign busy_o  = (state != S_IDLE);
   assign fetch_o = (state == S_FETCH);
endmodule

// File: rtl/dma_job_regs.sv
module dma_job_regs
   import dma_job_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cyc_i,
   input  logic              stb_i,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] adr_i,
   input  logic [WORD_W-1:0] dat_i,
   output logic [WORD_W-1:0] dat_o,
   output logic              ack_o,
   output logic              stall_o,
   output logic [WORD_W-1:0] carrier_addr_o,
   output logic [WORD_W-1:0] host_lo_o,
   output logic [WORD_W-1:0] host_hi_o,
   output logic [WORD_W-1:0] byte_count_o,
   output logic [WORD_W-1:0] next_lo_o,
   output logic [WORD_W-1:0] next_hi_o,
   output logic              direction_o,
   output logic [1:0]        swap_mode_o,
   output logic              start_h2c_o,
   output logic              start_c2h_o,
   output logic              abort_o,
   output logic              fetch_next_o,
   input  logic              desc_valid_i,
   input  logic [WORD_W-1:0] desc_word_i,
   input  logic              seg_done_i,
   input  logic              seg_error_i,
   input  logic [WORD_W-1:0] swap_din_i,
   output logic [WORD_W-1:0] swap_dout_o,
   output logic              irq_o
);
   localparam int IDX_W = ADDR_W - 2;
   localparam int DW_W  = $clog2(DESC_WORDS);

   if (ADDR_W < 6) begin : g_bad_addr
      $error("dma_job_regs: ADDR_W must be at least 6");
   end

   logic [WORD_W-1:0] attr_q;
   logic [IDX_W-1:0]  widx;
   logic              req, wr, busy, fetching;
   logic [DW_W-1:0]   didx;
   job_status_e       job_status;

   assign req   = cyc_i && stb_i;
   assign wr    = req && we_i;
   assign widx  = adr_i[ADDR_W-1:2];

   logic go, halt, iclr;
   assign go   = wr && (widx == IDX_W'(RI_CTRL)) && dat_i[0] && !busy;
   assign halt = wr && (widx == IDX_W'(RI_CTRL)) && dat_i[1] && busy;
   assign iclr = wr && (widx == IDX_W'(RI_ICLR)) && dat_i[0];

   dma_job_seq #(.NWORDS(DESC_WORDS)) u_seq (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .go_i        (go),
      .halt_i      (halt),
      .irq_clr_i   (iclr),
      .seg_done_i  (seg_done_i),
      .seg_error_i (seg_error_i),
      .desc_valid_i(desc_valid_i),
      .chain_i     (attr_q[1]),
      .dir_i       (attr_q[0]),
      .desc_dir_i  (desc_word_i[0]),
      .status_o    (job_status),
      .busy_o      (busy),
      .fetch_o     (fetching),
      .word_idx_o  (didx),
      .irq_o       (irq_o),
      .start_h2c_o (start_h2c_o),
      .start_c2h_o (start_c2h_o),
      .abort_o     (abort_o),
      .fetch_next_o(fetch_next_o)
   );

   // job registers: bus writes while idle, descriptor loads while fetching
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         carrier_addr_o <= '0;
         host_lo_o      <= '0;
         host_hi_o      <= '0;
         byte_count_o   <= '0;
         next_lo_o      <= '0;
         next_hi_o      <= '0;
         attr_q         <= '0;
         swap_mode_o    <= 2'd0;
      end else if (fetching) begin
         if (desc_valid_i) begin
            unique case (didx)
               DW_W'(0): carrier_addr_o <= desc_word_i;
               DW_W'(1): host_lo_o      <= desc_word_i;
               DW_W'(2): host_hi_o      <= desc_word_i;
               DW_W'(3): byte_count_o   <= desc_word_i;
               DW_W'(4): next_lo_o      <= desc_word_i;
               DW_W'(5): next_hi_o      <= desc_word_i;
               default:  attr_q         <= desc_word_i;
            endcase
         end
      end else if (wr && !busy) begin
         unique case (widx)
            IDX_W'(RI_CTRL): if (dat_i[0]) swap_mode_o <= dat_i[3:2];
            IDX_W'(RI_HLO):  host_lo_o      <= dat_i;
            IDX_W'(RI_HHI):  host_hi_o      <= dat_i;
            IDX_W'(RI_CNT):  byte_count_o   <= dat_i;
            IDX_W'(RI_NLO):  next_lo_o      <= dat_i;
            IDX_W'(RI_NHI):  next_hi_o      <= dat_i;
            IDX_W'(RI_ATTR): attr_q         <= dat_i;
            IDX_W'(RI_CARR): carrier_addr_o <= dat_i;
            default: ;
         endcase
      end
   end

   logic [WORD_W-1:0] rd_mux;
   always_comb begin
      unique case (widx)
         IDX_W'(RI_CTRL): rd_mux = {{(WORD_W-4){1'b0}}, swap_mode_o, 2'b00};
         IDX_W'(RI_STAT): rd_mux = {{(WORD_W-3){1'b0}}, job_status};
         IDX_W'(RI_ICLR): rd_mux = {{(WORD_W-1){1'b0}}, irq_o};
         IDX_W'(RI_HLO):  rd_mux = host_lo_o;
         IDX_W'(RI_HHI):  rd_mux = host_hi_o;
         IDX_W'(RI_CNT):  rd_mux = byte_count_o;
         IDX_W'(RI_NLO):  rd_mux = next_lo_o;
         IDX_W'(RI_NHI):  rd_mux = next_hi_o;
         IDX_W'(RI_ATTR): rd_mux = attr_q;
         IDX_W'(RI_CARR): rd_mux = carrier_addr_o;
         default:         rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ack_o <= 1'b0;
         dat_o <= '0;
      end else begin
         ack_o <= req;
         if (req && !we_i) dat_o <= rd_mux;
      end
   end

   assign stall_o     = 1'b0;
   assign direction_o = attr_q[0];

   dma_lane_swap #(.W(WORD_W)) u_swap (
      .mode_i(swap_mode_o),
      .din_i (swap_din_i),
      .dout_o(swap_dout_o)
   );
endmodule

// File: rtl/dma_job_regs_chk.sv
module dma_job_regs_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       cyc_i,
   input logic       stb_i,
   input logic       ack_o,
   input logic       start_h2c_o,
   input logic       start_c2h_o,
   input logic       abort_o,
   input logic       fetch_next_o,
   input logic       irq_o,
   input logic [1:0] swap_mode_o,
   input logic [2:0] status_i
);
   // R1
   ack_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_i && stb_i) |=> ack_o);

   // R2
   strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({start_h2c_o, start_c2h_o, abort_o, fetch_next_o}));

   // R2
   start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_h2c_o || start_c2h_o) |-> (status_i == 3'd2));

   // R3
   swap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (status_i == 3'd2 && $past(status_i) == 3'd2) |-> $stable(swap_mode_o));

   // R4
   irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> (status_i == 3'd1 || status_i == 3'd3));

   // R5
   fetch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fetch_next_o |-> (status_i == 3'd2 && !$rose(irq_o)));

   // R7
   abort_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      abort_o |-> (status_i == 3'd4 && !$rose(irq_o)));
endmodule

bind dma_job_regs dma_job_regs_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cyc_i       (cyc_i),
   .stb_i       (stb_i),
   .ack_o       (ack_o),
   .start_h2c_o (start_h2c_o),
   .start_c2h_o (start_c2h_o),
   .abort_o     (abort_o),
   .fetch_next_o(fetch_next_o),
   .irq_o       (irq_o),
   .swap_mode_o (swap_mode_o),
   .status_i    (job_status)
);

// File: tb/dma_job_regs_test.sv
`timescale 1ns/1ps
module dma_job_regs_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc = 0, stb = 0, we = 0;
   logic [5:0]  adr = '0;
   logic [31:0] wdat = '0;
   logic [31:0] rdat;
   logic        ack, stall;
   logic [31:0] carr, hlo, hhi, cnt, nlo, nhi;
   logic        dir;
   logic [1:0]  swm;
   logic        s_h2c, s_c2h, abrt, fnext, irq;
   logic        dvalid = 0;
   logic [31:0] dword = '0;
   logic        sdone = 0, serr = 0;
   logic [31:0] sw_in = '0, sw_out;

   int n_chk = 0, n_err = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   dma_job_regs #(.ADDR_W(6)) uut (
      .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we),
      .adr_i(adr), .dat_i(wdat), .dat_o(rdat), .ack_o(ack), .stall_o(stall),
      .carrier_addr_o(carr), .host_lo_o(hlo), .host_hi_o(hhi),
      .byte_count_o(cnt), .next_lo_o(nlo), .next_hi_o(nhi),
      .direction_o(dir), .swap_mode_o(swm), .start_h2c_o(s_h2c),
      .start_c2h_o(s_c2h), .abort_o(abrt), .fetch_next_o(fnext),
      .desc_valid_i(dvalid), .desc_word_i(dword), .seg_done_i(sdone),
      .seg_error_i(serr), .swap_din_i(sw_in), .swap_dout_o(sw_out),
      .irq_o(irq));

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: read acks pop the expected queue
   logic rd_q = 1'b0;
   always @(posedge clk) rd_q <= cyc && stb && !we;
   always @(negedge clk) begin
      if (ack && rd_q) begin
         if (sb_q.size() == 0) chk("R1 unexpected read ack", 32'd1, 32'd0);
         else begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, rdat, it.exp);
         end
      end
   end

   task automatic bus_wr(logic [5:0] a, logic [31:0] d);
      @(negedge clk);
      cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
      @(negedge clk);
      cyc = 0; stb = 0; we = 0;
   endtask

   task automatic bus_rd(logic [5:0] a, logic [31:0] exp, string tag);
      sb_item_t it;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      @(negedge clk);
      cyc = 1; stb = 1; we = 0; adr = a;
      @(negedge clk);
      cyc = 0; stb = 0;
      @(negedge clk);
   endtask

   task automatic seg_pulse(bit is_err);
      @(negedge clk);
      if (is_err) serr = 1; else sdone = 1;
      @(negedge clk);
      serr = 0; sdone = 0;
   endtask

   task automatic feed_desc(logic [31:0] w0, w1, w2, w3, w4, w5, w6);
      logic [31:0] words [7];
      words = '{w0, w1, w2, w3, w4, w5, w6};
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         dvalid = 1; dword = words[i];
      end
      @(negedge clk);
      dvalid = 0; dword = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         if (sb_q.size() != 0) chk("R1 reads left unanswered", sb_q.size(), 0);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      sw_in = 32'h11223344;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 irq after reset", irq, 0);
      chk("R10 strobes after reset", {s_h2c, s_c2h, abrt, fnext}, 0);
      rst_n = 1;
      bus_rd(6'h04, 32'd0, "R10 status idle");
      bus_rd(6'h14, 32'd0, "R10 count zero");

      // R1 register map and ack timing
      bus_wr(6'h0C, 32'h1234_5678);
      chk("R1 ack after write", {ack, stall}, 2'b10);
      bus_wr(6'h10, 32'h0000_0009);
      bus_wr(6'h14, 32'h0000_0100);
      bus_wr(6'h18, 32'h2002_0000);
      bus_wr(6'h1C, 32'h0000_0001);
      bus_wr(6'h24, 32'h0000_4000);
      bus_wr(6'h20, 32'h0);
      bus_rd(6'h0C, 32'h1234_5678, "R1 host low");
      bus_rd(6'h10, 32'h0000_0009, "R1 host high");
      bus_rd(6'h14, 32'h0000_0100, "R1 count");
      bus_rd(6'h18, 32'h2002_0000, "R1 next low");
      bus_rd(6'h1C, 32'h0000_0001, "R1 next high");
      bus_rd(6'h24, 32'h0000_4000, "R1 carrier");

      // R2 start toward carrier-to-host, R3 swap mode 1
      bus_wr(6'h00, 32'h5);
      chk("R2 c2h strobe", {s_h2c, s_c2h}, 2'b01);
      chk("R2 direction", dir, 0);
      @(negedge clk);
      chk("R2 strobe one cycle", {s_h2c, s_c2h}, 2'b00);
      bus_rd(6'h04, 32'd2, "R2 status busy");
      chk("R3 mode1 full reverse", sw_out, 32'h4433_2211);
      // R9 writes while busy ignored
      bus_wr(6'h14, 32'hDEAD);
      bus_wr(6'h00, 32'hD);
      chk("R9 restart ignored", {s_h2c, s_c2h}, 2'b00);
      bus_rd(6'h14, 32'h0000_0100, "R9 count unchanged");
      chk("R9 swap mode unchanged", sw_out, 32'h4433_2211);
      // R4 completion
      seg_pulse(0);
      chk("R4 irq raised", irq, 1);
      bus_rd(6'h04, 32'd1, "R4 status done");
      // R8 clear
      bus_wr(6'h08, 32'h1);
      chk("R8 irq cleared", irq, 0);

      // R3 remaining swap modes
      bus_wr(6'h00, 32'h1);
      chk("R3 mode0 pass", sw_out, 32'h1122_3344);
      seg_pulse(0); bus_wr(6'h08, 32'h1);
      bus_wr(6'h00, 32'h9);
      chk("R3 mode2 half swap", sw_out, 32'h3344_1122);
      seg_pulse(0); bus_wr(6'h08, 32'h1);
      bus_wr(6'h00, 32'hD);
      chk("R3 mode3 byte in half", sw_out, 32'h2211_4433);
      bus_rd(6'h00, 32'hC, "R3 mode readback");
      seg_pulse(0); bus_wr(6'h08, 32'h1);

      // R2 host-to-carrier direction
      bus_wr(6'h20, 32'h1);
      bus_wr(6'h00, 32'h1);
      chk("R2 h2c strobe", {s_h2c, s_c2h}, 2'b10);
      chk("R2 direction h2c", dir, 1);
      seg_pulse(0); bus_wr(6'h08, 32'h1);

      // R5 chained descriptor
      bus_wr(6'h20, 32'h2);
      bus_wr(6'h00, 32'h1);
      chk("R5 first segment c2h", {s_h2c, s_c2h}, 2'b01);
      seg_pulse(0);
      chk("R5 fetch strobe", fnext, 1);
      chk("R5 no irq on chain", irq, 0);
      bus_rd(6'h04, 32'd2, "R5 status stays busy");
      feed_desc(32'hC0, 32'hA0, 32'hA1, 32'h80, 32'hB0, 32'hB1, 32'h1);
      chk("R5 restart h2c", {s_h2c, s_c2h}, 2'b10);
      chk("R5 direction loaded", dir, 1);
      chk("R5 carrier loaded", carr, 32'hC0);
      bus_rd(6'h0C, 32'hA0, "R5 host low loaded");
      bus_rd(6'h10, 32'hA1, "R5 host high loaded");
      bus_rd(6'h14, 32'h80, "R5 count loaded");
      bus_rd(6'h1C, 32'hB1, "R5 next high loaded");
      bus_rd(6'h20, 32'h1, "R5 attr loaded");
      seg_pulse(0);
      chk("R5 chain end irq", irq, 1);
      bus_rd(6'h04, 32'd1, "R5 status done");
      bus_wr(6'h08, 32'h1);

      // R6 error during segment
      bus_wr(6'h20, 32'h0);
      bus_wr(6'h00, 32'h1);
      seg_pulse(1);
      chk("R6 irq on error", irq, 1);
      bus_rd(6'h04, 32'd3, "R6 status error");
      bus_wr(6'h08, 32'h1);
      // R6 error during fetch
      bus_wr(6'h20, 32'h2);
      bus_wr(6'h00, 32'h1);
      seg_pulse(0);
      seg_pulse(1);
      chk("R6 irq on fetch error", irq, 1);
      bus_rd(6'h04, 32'd3, "R6 status error in fetch");
      bus_wr(6'h08, 32'h1);

      // R7 abort
      bus_wr(6'h20, 32'h0);
      bus_wr(6'h00, 32'h1);
      bus_wr(6'h00, 32'h2);
      chk("R7 abort strobe", abrt, 1);
      chk("R7 no irq", irq, 0);
      bus_rd(6'h04, 32'd4, "R7 status abort");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule